// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder Model

This block is a synthesizable, device-side model of an asynchronous EDO DRAM with an 8-bit data path, scaled down to a small internal array. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable, together with the multiplexed address and the incoming data byte. The block works out which operation is requested from the order in which the strobes fall and rise, and from the levels of the other controls at those moments. It then performs a read, a write, a page-mode access, a read-modify-write or a refresh.

The data bus is split into an output byte and an output-enable flag. Read data follows extended-data-out rules: the byte stays driven after the column strobe rises and is released only by specific events. An internal refresh row counter serves column-before-row refresh. Every refresh the model performs is reported for one clock on a strobe output, together with the row that was refreshed. Every strobe change reaches the outputs two clock cycles after the edge that first samples it.

Top module: `edo_strobe_model`

## Requirements
- R1: After reset the data output is not driven, the refresh strobe is low and the refresh row counter is zero.
- R2: A falling row strobe while the column strobe is high latches the row from the address. A later falling column strobe latches the column. If write enable is low at that column fall, the sampled data byte is stored at index {row, column}, whatever the output enable level, and the bus is not driven.
- R3: A falling column strobe with write enable high reads the byte at {row, column}. The byte is driven on the bus while output enable is low.
- R4: Read data stays driven after the column strobe rises, as long as the row strobe stays low and output enable stays low.
- R5: Driven read data is released when output enable is high, when write enable falls, or when the row and column strobes are both high.
- R6: While the row strobe stays low, each further column strobe fall reads or writes a new column of the same row, without the row being latched again.
- R7: After a read, if write enable falls while both strobes stay low, the sampled data byte is written to the same {row, column} and the output is released.
- R8: A row strobe fall while the column strobe is already low is a column-before-row refresh. It pulses the refresh strobe with the current counter value, then increments the counter, which wraps from its maximum to zero. It does not start any read drive.
- R9: A row strobe that falls with the column strobe high and rises without any column strobe fall pulses the refresh strobe with the latched row. The refresh counter is unchanged. A cycle that had a column access produces no refresh pulse when the row strobe rises.
- R10: Hidden refresh: after a read, with the column strobe held low, the row strobe rising and falling again performs a column-before-row refresh while the read byte stays driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 8 | Data byte into the array |
| dq_out | output | 8 | Read data byte |
| dq_oe | output | 1 | High while dq_out is driven |
| refresh_stb | output | 1 | One-clock pulse per refresh performed |
| refresh_row | output | ROW_W | Row refreshed in the pulsing cycle |

## Verification
The bench exercises the data hold after the column strobe rises. A model without extended output would drop the byte at once, and one that never releases it would keep driving through output enable high, write enable falling or standby. It runs a read-modify-write, then reads the location back. A design that ignored the late write-enable fall would return the old byte. It mixes column-before-row, row-only and hidden refresh, and runs the counter past its wrap. A design that counted on row-only refresh, refreshed after a normal access, or dropped the output during hidden refresh would show the wrong refresh count, the wrong row or a released bus.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] byte_t;

    // bit positions of the strobes inside the sampled strobe vector
    typedef enum int {
        STB_RAS = 0,
        STB_CAS = 1,
        STB_WE  = 2
    } strobe_pos_e;

    localparam int STB_W = 3;
endpackage

// File: rtl/edo_edge_det.sv
module edo_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.cur  = raw;
        smp_d.prev = smp_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;  // strobes idle high
        else        smp_q <= smp_d;
    end

    assign cur  = smp_q.cur;
    assign prev = smp_q.prev;
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array
    import edo_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            wdata,
    output byte_t            rdata
);
    localparam int DEPTH = 1 << IDX_W;

    byte_t cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (wr_en) begin
            cell_q[idx] <= wdata;
        end
    end

    assign rdata = cell_q[idx];
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (inc) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    // R8
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (row_q == $past(row_q) + {{(ROW_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/edo_strobe_model.sv
module edo_strobe_model
    import edo_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              refresh_stb,
    output logic [ROW_W-1:0]  refresh_row
);
    localparam int IDX_W = ROW_W + COL_W;

    typedef struct packed {
        logic              oe_n;
        logic [ADDR_W-1:0] addr;
        byte_t             din;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              active;
        logic              cas_seen;
        logic              cbr;
        logic              dvalid;
        logic              dq_oe;
        byte_t             dout;
        logic              ref_v;
        logic [ROW_W-1:0]  ref_row;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [STB_W-1:0] stb_cur, stb_prev;
    logic             ras_fall, ras_rise, cas_fall, we_fall;
    logic             ras_low, cas_low;
    logic             mem_we;
    logic [COL_W-1:0] col_sel;
    byte_t            mem_rdata;
    logic             ref_inc;
    logic [ROW_W-1:0] ref_cnt;

    edo_edge_det #(.W(STB_W)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({we_n, cas_n, ras_n}),
        .cur   (stb_cur),
        .prev  (stb_prev)
    );

    assign ras_low  = !stb_cur[STB_RAS];
    assign cas_low  = !stb_cur[STB_CAS];
    assign ras_fall = stb_prev[STB_RAS] && ras_low;
    assign ras_rise = !stb_prev[STB_RAS] && !ras_low;
    assign cas_fall = stb_prev[STB_CAS] && cas_low;
    assign we_fall  = stb_prev[STB_WE] && !stb_cur[STB_WE];

    edo_cell_array #(.IDX_W(IDX_W)) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mem_we),
        .idx   ({ctl_q.row, col_sel}),
        .wdata (ctl_q.din),
        .rdata (mem_rdata)
    );

    edo_refresh_ctr #(.ROW_W(ROW_W)) i_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .row   (ref_cnt)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.oe_n  = oe_n;
        ctl_d.addr  = addr;
        ctl_d.din   = dq_in;
        ctl_d.ref_v = 1'b0;
        mem_we      = 1'b0;
        ref_inc     = 1'b0;
        col_sel     = ctl_q.col;

        if (ras_fall) begin
            if (cas_low) begin
                // column strobe already low: refresh from internal counter
                ctl_d.cbr     = 1'b1;
                ctl_d.active  = 1'b0;
                ctl_d.ref_v   = 1'b1;
                ctl_d.ref_row = ref_cnt;
                ref_inc       = 1'b1;
            end else begin
                ctl_d.row      = ctl_q.addr[ROW_W-1:0];
                ctl_d.active   = 1'b1;
                ctl_d.cas_seen = 1'b0;
                ctl_d.cbr      = 1'b0;
            end
        end

        if (ras_rise) begin
            if (ctl_q.active && !ctl_q.cas_seen && !ctl_q.cbr) begin
                ctl_d.ref_v   = 1'b1;
                ctl_d.ref_row = ctl_q.row;
            end
            ctl_d.active = 1'b0;
            ctl_d.cbr    = 1'b0;
        end

        if (cas_fall && ctl_q.active && !ctl_q.cbr) begin
            col_sel        = ctl_q.addr[COL_W-1:0];
            ctl_d.col      = col_sel;
            ctl_d.cas_seen = 1'b1;
            if (!stb_cur[STB_WE]) begin
                mem_we       = 1'b1;
                ctl_d.dvalid = 1'b0;
            end else begin
                ctl_d.dvalid = 1'b1;
                ctl_d.dout   = mem_rdata;
            end
        end else if (we_fall && ctl_q.active && ctl_q.cas_seen && cas_low) begin
            // late write enable: read-modify-write to the open location
            mem_we = 1'b1;
        end

        if (we_fall) ctl_d.dvalid = 1'b0;
        if (!ras_low && !cas_low) ctl_d.dvalid = 1'b0;

        ctl_d.dq_oe = ctl_d.dvalid && !ctl_q.oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign dq_out      = ctl_q.dout;
    assign dq_oe       = ctl_q.dq_oe;
    assign refresh_stb = ctl_q.ref_v;
    assign refresh_row = ctl_q.ref_row;

    // R5
    standby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_cur[STB_RAS] && stb_cur[STB_CAS]) |=> !dq_oe);

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.oe_n |=> !dq_oe);

    // R2
    write_row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ras_low);

    // R7
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !dq_oe);

    // R8
    cbr_no_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_inc |-> !mem_we);
endmodule

// File: tb/test_edo_strobe_model.sv
`timescale 1ns/1ps
module test_edo_strobe_model;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [7:0]        dq_out;
    logic              dq_oe;
    logic              refresh_stb;
    logic [ROW_W-1:0]  refresh_row;

    always #2 clk = ~clk;

    edo_strobe_model #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) i_edo_strobe_model (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .refresh_stb(refresh_stb), .refresh_row(refresh_row)
    );

    typedef struct {
        string      tag;
        bit         is_ref;
        bit         oe;
        logic [7:0] data;
        int         cnt;
        int         row;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    int    ref_cnt = 0;
    int    ref_last = 0;
    bit    done = 1'b0;

    // monitor: counts refresh pulses and compares queued expectations
    always @(negedge clk) begin
        if (rst_n && refresh_stb) begin
            ref_cnt++;
            ref_last = int'(refresh_row);
        end
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (it.is_ref) begin
                if (ref_cnt != it.cnt || (it.cnt > 0 && ref_last != it.row)) begin
                    errors++;
                    $display("FAIL %s refresh count/row actual %0d/%0d expected %0d/%0d",
                             it.tag, ref_cnt, ref_last, it.cnt, it.row);
                end
            end else begin
                if (dq_oe !== it.oe || (it.oe && dq_out !== it.data)) begin
                    errors++;
                    $display("FAIL %s bus oe/data actual %0b/%02h expected %0b/%02h",
                             it.tag, dq_oe, dq_out, it.oe, it.data);
                end
            end
        end
    end

    task automatic drv(input bit r, input bit c, input bit w, input bit o,
                       input int a, input logic [7:0] d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        addr  = ADDR_W'(a);
        dq_in = d;
        repeat (3) @(negedge clk);
    endtask

    task automatic exp_bus(input string tag, input bit oe, input logic [7:0] d);
        item_t it;
        it.tag = tag; it.is_ref = 1'b0; it.oe = oe; it.data = d; it.cnt = 0; it.row = 0;
        sb_q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic exp_ref(input string tag, input int cnt, input int row);
        item_t it;
        it.tag = tag; it.is_ref = 1'b1; it.oe = 1'b0; it.data = '0; it.cnt = cnt; it.row = row;
        sb_q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic cbr_cycle();
        drv(1, 0, 1, 1, 0, 8'h00);
        drv(0, 0, 1, 1, 0, 8'h00);
        drv(1, 0, 1, 1, 0, 8'h00);
        drv(1, 1, 1, 1, 0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        exp_bus("R1", 0, 8'h00);
        exp_ref("R1", 0, 0);

        // R2 early write with OE low, then R6 page write to a second column
        drv(0, 1, 1, 0, 3, 8'h00);
        drv(0, 0, 0, 0, 5, 8'hA5);
        exp_bus("R2", 0, 8'h00);
        drv(0, 1, 0, 0, 5, 8'hA5);
        drv(0, 0, 0, 0, 6, 8'h3C);
        drv(0, 1, 1, 0, 6, 8'h3C);
        drv(1, 1, 1, 1, 0, 8'h00);
        exp_ref("R9", 0, 0);  // accessed cycle: no refresh on RAS rise

        // R3 read, R4 EDO hold, R6 page read, R5 OE release and WE release
        drv(0, 1, 1, 0, 3, 8'h00);
        drv(0, 0, 1, 0, 5, 8'h00);
        exp_bus("R3", 1, 8'hA5);
        drv(0, 1, 1, 0, 5, 8'h00);
        exp_bus("R4", 1, 8'hA5);
        drv(0, 0, 1, 0, 6, 8'h00);
        exp_bus("R6", 1, 8'h3C);
        drv(0, 0, 1, 1, 6, 8'h00);
        exp_bus("R5", 0, 8'h00);
        drv(0, 1, 1, 0, 6, 8'h00);
        exp_bus("R4", 1, 8'h3C);
        drv(0, 1, 0, 0, 6, 8'h00);
        exp_bus("R5", 0, 8'h00);
        drv(0, 1, 1, 0, 6, 8'h00);
        drv(0, 0, 1, 0, 5, 8'h00);
        exp_bus("R3", 1, 8'hA5);
        drv(0, 1, 1, 0, 5, 8'h00);
        exp_bus("R4", 1, 8'hA5);
        drv(1, 1, 1, 0, 0, 8'h00);
        exp_bus("R5", 0, 8'h00);  // standby releases with OE still low

        // R7 read-modify-write then read back
        drv(0, 1, 1, 0, 3, 8'h00);
        drv(0, 0, 1, 0, 5, 8'h5A);
        exp_bus("R7", 1, 8'hA5);
        drv(0, 0, 0, 0, 5, 8'h5A);
        exp_bus("R7", 0, 8'h00);
        drv(0, 1, 1, 1, 5, 8'h00);
        drv(1, 1, 1, 1, 0, 8'h00);
        drv(0, 1, 1, 0, 3, 8'h00);
        drv(0, 0, 1, 0, 5, 8'h00);
        exp_bus("R7", 1, 8'h5A);
        drv(0, 1, 1, 0, 5, 8'h00);
        drv(1, 1, 1, 1, 0, 8'h00);

        // R8 column-before-row refresh
        cbr_cycle();
        exp_ref("R8", 1, 0);
        exp_bus("R8", 0, 8'h00);
        cbr_cycle();
        exp_ref("R8", 2, 1);

        // R9 row-only refresh uses the latched row, counter untouched
        drv(0, 1, 1, 1, 9, 8'h00);
        drv(1, 1, 1, 1, 9, 8'h00);
        exp_ref("R9", 3, 9);
        cbr_cycle();
        exp_ref("R8", 4, 2);

        // R10 hidden refresh keeps read data driven
        drv(0, 1, 1, 0, 3, 8'h00);
        drv(0, 0, 1, 0, 6, 8'h00);
        exp_bus("R10", 1, 8'h3C);
        drv(1, 0, 1, 0, 6, 8'h00);
        exp_bus("R10", 1, 8'h3C);
        exp_ref("R10", 4, 2);
        drv(0, 0, 1, 0, 6, 8'h00);
        exp_ref("R10", 5, 3);
        exp_bus("R10", 1, 8'h3C);
        drv(1, 0, 1, 0, 6, 8'h00);
        drv(1, 1, 1, 0, 0, 8'h00);
        exp_bus("R5", 0, 8'h00);

        // R8 counter wrap
        for (int i = 0; i < 12; i++) cbr_cycle();
        exp_ref("R8", 17, 15);
        cbr_cycle();
        exp_ref("R8", 18, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired before stimulus completed");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule